// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Port

This block is a processor-side asynchronous serial transceiver. Software uses a two-entry register window. A single select line picks either the data register or the control/status register, and write and read strobes act on the selected register. A write to the data register queues a character for sending. A read of the data register returns the last character received. A write to the control register chooses even or odd parity. A read of the status register returns the transmit and receive flags.

On the line side, each character is framed with a low start bit, seven data bits sent least significant first, a parity bit and a high stop bit. A holding register sits in front of the transmit shifter, so software can queue the next character while the current one is still on the wire. The receiver runs from a tick at sixteen times the bit rate and confirms the start bit at its midpoint. It samples every later bit at its midpoint and reports parity, framing and overrun errors as separate flags. One bit time is `OVERSAMPLE * CLK_DIV` clock cycles.

Top module: `async_serial_port`

## Requirements
- R1: The serial output `txd` is 1 after reset and whenever no character is being sent.
- R2: A transmitted frame is a 0 start bit, then data bits 0..6 in that order, then a parity bit, then a 1 stop bit. Each bit lasts exactly 16 baud ticks, which is 16*CLK_DIV clock cycles.
- R3: A control write (`sel`=1) sets the parity mode from `wdata[0]`: 0 selects even parity and 1 selects odd parity. The mode is used both for transmitted parity bits and for checking received ones.
- R4: Status bit 0 (transmit holding empty) returns to 1 once a queued character moves into the shifter. A character written while another is being sent starts with its start bit exactly one frame (10 bit times) after the previous start bit.
- R5: A data write (`sel`=0) made while the holding register is full is discarded, and no frame is sent for it.
- R6: A read with `sel`=0 returns the received character in bits 6..0, with the upper bits 0. A read with `sel`=1 returns the status word: bit 0 transmit holding empty, bit 1 receive ready, bit 2 parity error, bit 3 framing error, bit 4 overrun, and all other bits 0. After reset the status word is 0x01.
- R7: A start bit counts only if the line is still low at its midpoint. A low pulse shorter than half a bit time produces no character.
- R8: Receive ready is set when a character's stop bit is sampled, and it is cleared by a data read.
- R9: The parity error flag shows whether the last received character failed the configured parity check.
- R10: The framing error flag is set when the stop bit is sampled as 0. The receiver then waits for the line to go high before it looks for a new start bit.
- R11: When a character completes while receive ready is still set, the overrun flag is set and the new character replaces the old one. A status read clears the overrun flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Register select: 0 data, 1 control/status |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; applies the read side effects |
| wdata | input | BUS_W | Write data |
| rdata | output | BUS_W | Read data of the selected register (combinational) |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |

## Verification
The bench goes after the transmit hand-off from holding register to shifter. It times two back-to-back frames to the cycle: a design that waits one extra tick would stretch the stop bit, and one that overwrites a full holding register would send a third frame. On the receive side it sends a short low glitch, which a receiver without midpoint confirmation would turn into a character. It also sends a frame with a low stop bit; a receiver that re-arms at once would read the low line as a new start. Finally it lets two characters arrive unread, to show whether the overrun flag is set and whether a status read clears it.

// File: rtl/asp_pkg.sv
package asp_pkg;
   // status word bit positions
   localparam int ST_TXE = 0;
   localparam int ST_RXR = 1;
   localparam int ST_PER = 2;
   localparam int ST_FER = 3;
   localparam int ST_OVR = 4;
   localparam int ST_BITS = 5;

   typedef enum logic [2:0] {
      RX_IDLE,
      RX_START,
      RX_DATA,
      RX_STOP,
      RX_WAITHI
   } rx_state_e;
endpackage

// File: rtl/asp_baud_tick.sv
module asp_baud_tick #(
   parameter int CLK_DIV = 27
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (CLK_DIV < 1) begin : g_bad_div
         initial $fatal(1, "CLK_DIV must be at least 1");
      end
      if (CLK_DIV == 1) begin : g_every
         assign tick = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(CLK_DIV);
         logic [CW-1:0] cnt;
         logic          tick_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt    <= '0;
               tick_q <= 1'b0;
            end else if (cnt == CW'(CLK_DIV - 1)) begin
               cnt    <= '0;
               tick_q <= 1'b1;
            end else begin
               cnt    <= cnt + 1'b1;
               tick_q <= 1'b0;
            end
         end
         assign tick = tick_q;

         // R2: ticks are single-cycle pulses so bit lengths stay exact
         a_r2_tick_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
      end
   endgenerate
endmodule

// File: rtl/asp_tx.sv
module asp_tx #(
   parameter int DATA_BITS  = 7,
   parameter int OVERSAMPLE = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 odd_par,
   input  logic                 load,
   input  logic [DATA_BITS-1:0] load_data,
   output logic                 hold_empty,
   output logic                 txd
);
   localparam int FRAME = DATA_BITS + 3;
   localparam int TW    = $clog2(OVERSAMPLE);
   localparam int BW    = $clog2(FRAME);

   logic                 hold_full;
   logic [DATA_BITS-1:0] hold_data;
   logic                 busy;
   logic [FRAME-1:0]     shreg;
   logic [TW-1:0]        tcnt;
   logic [BW-1:0]        bcnt;
   logic                 par;
   logic                 fin;
   logic                 start;

   always_comb begin
      par   = odd_par ? ~(^hold_data) : ^hold_data;
      fin   = busy && tick && (tcnt == TW'(OVERSAMPLE - 1)) && (bcnt == BW'(FRAME - 1));
      start = tick && hold_full && (!busy || fin);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_full <= 1'b0;
         hold_data <= '0;
         busy      <= 1'b0;
         shreg     <= '1;
         tcnt      <= '0;
         bcnt      <= '0;
      end else begin
         if (load && !hold_full) begin
            hold_data <= load_data;
            hold_full <= 1'b1;
         end
         if (start) begin
            shreg     <= {1'b1, par, hold_data, 1'b0};
            busy      <= 1'b1;
            tcnt      <= '0;
            bcnt      <= '0;
            hold_full <= 1'b0;
         end else if (tick && busy) begin
            if (tcnt == TW'(OVERSAMPLE - 1)) begin
               tcnt  <= '0;
               shreg <= {1'b1, shreg[FRAME-1:1]};
               if (bcnt == BW'(FRAME - 1)) busy <= 1'b0;
               else                        bcnt <= bcnt + 1'b1;
            end else begin
               tcnt <= tcnt + 1'b1;
            end
         end
      end
   end

   assign hold_empty = !hold_full;
   assign txd        = busy ? shreg[0] : 1'b1;

   // R2: a frame opens with a low start bit
   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);
   // R2: the line was high (stop bit) right before the shifter goes idle
   a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(txd));
   // R2: during a frame the line only moves on baud ticks
   a_r2_tick_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($past(tick) || $stable(txd)));
endmodule

// File: rtl/asp_rx.sv
module asp_rx
   import asp_pkg::*;
#(
   parameter int DATA_BITS  = 7,
   parameter int OVERSAMPLE = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick,
   input  logic                 rxd,
   input  logic                 odd_par,
   output logic                 done,
   output logic [DATA_BITS-1:0] rx_char,
   output logic                 par_err,
   output logic                 frm_err
);
   localparam int TW  = $clog2(OVERSAMPLE);
   localparam int BCW = $clog2(DATA_BITS + 1);

   logic             rx_meta, rx_s;
   rx_state_e        state;
   logic [TW-1:0]    tcnt;
   logic [BCW-1:0]   bcnt;
   logic [DATA_BITS:0] shreg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_meta <= 1'b1;
         rx_s    <= 1'b1;
      end else begin
         rx_meta <= rxd;
         rx_s    <= rx_meta;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= RX_IDLE;
         tcnt    <= '0;
         bcnt    <= '0;
         shreg   <= '0;
         done    <= 1'b0;
         rx_char <= '0;
         par_err <= 1'b0;
         frm_err <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            unique case (state)
               RX_IDLE: begin
                  if (!rx_s) begin
                     state <= RX_START;
                     tcnt  <= '0;
                  end
               end
               RX_START: begin
                  if (tcnt == TW'(OVERSAMPLE / 2 - 1)) begin
                     tcnt  <= '0;
                     bcnt  <= '0;
                     state <= rx_s ? RX_IDLE : RX_DATA;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_DATA: begin
                  if (tcnt == TW'(OVERSAMPLE - 1)) begin
                     tcnt  <= '0;
                     shreg <= {rx_s, shreg[DATA_BITS:1]};
                     if (bcnt == BCW'(DATA_BITS)) state <= RX_STOP;
                     else                         bcnt  <= bcnt + 1'b1;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_STOP: begin
                  if (tcnt == TW'(OVERSAMPLE - 1)) begin
                     tcnt    <= '0;
                     done    <= 1'b1;
                     rx_char <= shreg[DATA_BITS-1:0];
                     par_err <= (^shreg) ^ odd_par;
                     frm_err <= !rx_s;
                     state   <= rx_s ? RX_IDLE : RX_WAITHI;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_WAITHI: begin
                  if (rx_s) state <= RX_IDLE;
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   // R7: data sampling only begins after the start bit was seen low at mid-bit
   a_r7_start_confirmed: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_DATA && $past(state) == RX_START) |-> !$past(rx_s));
   // R10: after a low stop bit the receiver holds off until the line is high
   a_r10_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == RX_WAITHI && state == RX_IDLE) |-> $past(rx_s));
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
   import asp_pkg::*;
#(
   parameter int CLK_DIV    = 27,
   parameter int OVERSAMPLE = 16,
   parameter int DATA_BITS  = 7,
   parameter int BUS_W      = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             wr_en,
   input  logic             rd_en,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   output logic             txd,
   input  logic             rxd
);
   generate
      if (BUS_W < ST_BITS || BUS_W < DATA_BITS) begin : g_bad_bus
         initial $fatal(1, "BUS_W too narrow for status word or character");
      end
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         initial $fatal(1, "OVERSAMPLE must be even and at least 4");
      end
   endgenerate

   logic                 tick;
   logic                 odd_par;
   logic                 hold_empty;
   logic                 rx_done;
   logic [DATA_BITS-1:0] rx_char;
   logic                 rx_perr, rx_ferr;
   logic                 rx_ready, perr, ferr, ovr;
   logic [DATA_BITS-1:0] rx_hold;
   logic [BUS_W-1:0]     status;
   logic                 rd_data, rd_stat, wr_data, wr_ctrl;

   assign rd_data = rd_en && !sel;
   assign rd_stat = rd_en && sel;
   assign wr_data = wr_en && !sel;
   assign wr_ctrl = wr_en && sel;

   asp_baud_tick #(.CLK_DIV(CLK_DIV)) u_baud (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (tick)
   );

   asp_tx #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .odd_par   (odd_par),
      .load      (wr_data),
      .load_data (wdata[DATA_BITS-1:0]),
      .hold_empty(hold_empty),
      .txd       (txd)
   );

   asp_rx #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_rx (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .rxd    (rxd),
      .odd_par(odd_par),
      .done   (rx_done),
      .rx_char(rx_char),
      .par_err(rx_perr),
      .frm_err(rx_ferr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         odd_par  <= 1'b0;
         rx_ready <= 1'b0;
         rx_hold  <= '0;
         perr     <= 1'b0;
         ferr     <= 1'b0;
         ovr      <= 1'b0;
      end else begin
         if (wr_ctrl) odd_par <= wdata[0];
         if (rx_done) begin
            rx_hold  <= rx_char;
            perr     <= rx_perr;
            ferr     <= rx_ferr;
            rx_ready <= 1'b1;
         end else if (rd_data) begin
            rx_ready <= 1'b0;
         end
         if (rx_done && rx_ready && !rd_data) ovr <= 1'b1;
         else if (rd_stat)                    ovr <= 1'b0;
      end
   end

   always_comb begin
      status         = '0;
      status[ST_TXE] = hold_empty;
      status[ST_RXR] = rx_ready;
      status[ST_PER] = perr;
      status[ST_FER] = ferr;
      status[ST_OVR] = ovr;
   end

   assign rdata = sel ? status : BUS_W'(rx_hold);

   // R11: overrun only appears when an unread character was pending
   a_r11_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(rx_ready));
   // R11: a status read with no new overrun clears the flag
   a_r11_ovr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !rx_done) |=> !ovr);
   // R8: a data read with no new arrival clears receive ready
   a_r8_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data && !rx_done) |=> !rx_ready);
endmodule

// File: tb/async_serial_port_bench.sv
module async_serial_port_bench;
   localparam int DIV = 3;
   localparam int OS  = 16;
   localparam int BIT = DIV * OS;
   localparam int FR  = BIT * 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic       rxd = 1'b1;
   wire  [7:0] rdata;
   wire        txd;

   int checks = 0, errors = 0, cyc = 0, tx_frames = 0;
   bit finished = 1'b0;
   logic [7:0] tx_q[$];
   logic [6:0] rx_q[$];
   int         start_t[$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   async_serial_port #(.CLK_DIV(DIV), .OVERSAMPLE(OS), .DATA_BITS(7), .BUS_W(8)) u_async_serial_port (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd)
   );

   function automatic logic pbit(logic [6:0] c, logic odd);
      return odd ? ~(^c) : ^c;
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic wr(logic s, logic [7:0] d);
      @(negedge clk); sel = s; wdata = d; wr_en = 1'b1;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(logic s, output logic [7:0] d);
      @(negedge clk); sel = s; rd_en = 1'b1;
      #1 d = rdata;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic tx_char(logic [6:0] c, logic odd);
      tx_q.push_back({odd, c});
      wr(1'b0, {1'b0, c});
   endtask

   task automatic send_rx(logic [6:0] c, logic odd, logic bad_par, logic bad_stop, logic push);
      logic [9:0] f;
      f = {~bad_stop, pbit(c, odd) ^ bad_par, c, 1'b0};
      @(negedge clk);
      for (int i = 0; i < 10; i++) begin
         rxd = f[i];
         repeat (BIT) @(negedge clk);
      end
      rxd = 1'b1;
      if (push) rx_q.push_back(c);
      repeat (BIT) @(negedge clk);
   endtask

   task automatic check_rx_data(string req);
      logic [7:0] d;
      logic [6:0] e;
      rd(1'b0, d);
      if (rx_q.size() == 0) e = '0;
      else e = rx_q.pop_front();
      chk(req, d, {1'b0, e});
   endtask

   // transmit monitor: decodes frames on txd and compares with the scoreboard
   initial begin
      @(posedge rst_n);
      forever begin
         logic [9:0] f;
         logic [7:0] e;
         @(negedge txd);
         start_t.push_back(cyc);
         repeat (BIT / 2) @(negedge clk);
         for (int i = 0; i < 10; i++) begin
            f[i] = txd;
            if (i < 9) repeat (BIT) @(negedge clk);
         end
         tx_frames++;
         if (tx_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R5: unexpected frame actual 0x%0h expected none", f);
         end else begin
            e = tx_q.pop_front();
            chk(e[7] ? "R3 odd frame" : "R2 frame", f, {1'b1, pbit(e[6:0], e[7]), e[6:0], 1'b0});
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [7:0] d;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      rd(1'b1, d);
      chk("R6 reset status", d, 8'h01);
      chk("R1 idle after reset", txd, 1);

      // transmit, even then odd parity
      wr(1'b1, 8'h00);
      tx_char(7'h55, 1'b0);
      repeat (FR + BIT) @(negedge clk);
      wr(1'b1, 8'h01);
      tx_char(7'h23, 1'b1);
      repeat (FR + BIT) @(negedge clk);

      // double buffering and discarded write
      wr(1'b1, 8'h00);
      tx_char(7'h41, 1'b0);
      do rd(1'b1, d); while (!d[0]);
      tx_char(7'h3C, 1'b0);
      rd(1'b1, d);
      chk("R4 holding full while shifting", d[0], 0);
      wr(1'b0, 8'h7F);
      repeat (3 * FR) @(negedge clk);
      chk("R5 frames sent", tx_frames, 4);
      if (start_t.size() >= 4) chk("R4 back-to-back spacing", start_t[3] - start_t[2], FR);
      else chk("R4 back-to-back spacing", start_t.size(), 4);
      chk("R1 idle between frames", txd, 1);

      // receive, good character
      send_rx(7'h5A, 1'b0, 1'b0, 1'b0, 1'b1);
      rd(1'b1, d);
      chk("R8 ready set", d, 8'h03);
      check_rx_data("R6 data read");
      rd(1'b1, d);
      chk("R8 ready cleared by data read", d, 8'h01);

      // short glitch
      @(negedge clk); rxd = 1'b0;
      repeat (BIT / 4) @(negedge clk);
      rxd = 1'b1;
      repeat (FR) @(negedge clk);
      rd(1'b1, d);
      chk("R7 glitch rejected", d, 8'h01);

      // odd parity receive, good then bad
      wr(1'b1, 8'h01);
      send_rx(7'h11, 1'b1, 1'b0, 1'b0, 1'b1);
      rd(1'b1, d);
      chk("R3 odd parity accepted", d, 8'h03);
      check_rx_data("R3 odd data");
      send_rx(7'h11, 1'b1, 1'b1, 1'b0, 1'b1);
      rd(1'b1, d);
      chk("R9 parity error", d, 8'h07);
      check_rx_data("R9 data with parity error");

      // framing error and recovery
      wr(1'b1, 8'h00);
      send_rx(7'h30, 1'b0, 1'b0, 1'b1, 1'b1);
      rd(1'b1, d);
      chk("R10 framing error", d, 8'h0B);
      check_rx_data("R10 data with framing error");
      send_rx(7'h2B, 1'b0, 1'b0, 1'b0, 1'b1);
      rd(1'b1, d);
      chk("R10 recovery after low stop", d, 8'h03);
      check_rx_data("R10 recovered data");

      // overrun
      send_rx(7'h12, 1'b0, 1'b0, 1'b0, 1'b0);
      send_rx(7'h34, 1'b0, 1'b0, 1'b0, 1'b1);
      rd(1'b1, d);
      chk("R11 overrun set", d, 8'h13);
      rd(1'b1, d);
      chk("R11 overrun cleared by status read", d, 8'h03);
      check_rx_data("R11 newest character kept");
      rd(1'b1, d);
      chk("R8 ready cleared after overrun", d, 8'h01);

      summary();
   end
endmodule